// File: doc/BRIEF.md
# Function Configuration Space with Appendable Capability Chain

This block holds the 256-byte configuration register space of one bus function. It answers read and write requests of one, two or four bytes and refuses any request that is not naturally aligned. The fixed header carries the vendor and device identity, a status word whose capability-present flag follows the contents of the capability list, a pointer to the first capability, a writable interrupt-line byte and a constant interrupt-pin byte. Every other header offset reads as zero.

Capability entries are added while the function is running, through a separate load port. Each entry is four bytes and is stored in the next free dword slot from a fixed base offset upward. The hardware builds the next-pointer chain itself, so software walking the list sees the entries in the order they were loaded, and the last entry points to zero. When every slot is taken, a further load is refused with an error and the list does not change.

Every request gets a response exactly one cycle later, carrying error, read data or both. A load gets a done pulse one cycle later, with an error flag when the list is full.

Top module: `cfgsp_func`

## Requirements
- R1: A request is refused (rsp_err=1, rsp_rdata=0, no state change) when its offset is not a multiple of its width, or when its size code is 3. Size codes: 0 = one byte, 1 = two bytes, 2 = four bytes.
- R2: Every request receives rsp_valid exactly one cycle after it is presented. Read data is right-justified: the byte at the requested offset appears in rsp_rdata[7:0], and bytes above the access width are zero. Writes return rdata 0.
- R3: The dword at offset 0x00 reads as {device ID, vendor ID}, with the vendor ID in the low half. Single-byte reads of offsets 0 to 3 return its bytes in ascending order.
- R4: The interrupt-line byte at 0x3C is read/write. A wider write covering 0x3C changes only that byte. The interrupt-pin byte at 0x3D keeps its constant value, and 0x3E to 0x3F stay zero.
- R5: Bit 4 of the 16-bit status register at 0x06 (bit 20 of dword 0x04) reads 0 while the list is empty and 1 once any entry is loaded.
- R6: The byte at 0x34 reads 0 while the list is empty and 0x44 otherwise. This value is above 0x40.
- R7: An entry dword reads {data byte 1, data byte 0, next pointer, ID}, with the ID in bits 7:0. cap_load_data[7:0] is data byte 0. For example, ID 9 with data 16'h2211 as the last entry reads 0x22110009.
- R8: Entry k sits at offset 0x44+4k. Its next pointer is the offset of entry k+1 when that entry exists and 0 otherwise, so the chain follows load order.
- R9: A load while CAP_MAX entries are held returns cap_done with cap_err=1 and leaves every entry and both header fields unchanged. Slots that are not loaded read as zero.
- R10: Writes to the identity, status, capability pointer and entry offsets have no effect. Offsets with no register read as zero.
- R11: When a read and a load fall in the same cycle, the read returns the state from before the load.
- R12: After reset the list is empty and the interrupt line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in configuration space |
| req_size | input | 2 | Access size code (0/1/2 = 1/2/4 bytes, 3 invalid) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data, right-justified |
| cap_load_valid | input | 1 | Append one capability entry |
| cap_load_id | input | 8 | Capability ID |
| cap_load_data | input | 16 | Two capability data bytes |
| cap_done | output | 1 | Load processed (one cycle after load) |
| cap_err | output | 1 | Load refused, list full |

## Verification
A configuration read and a capability load can land in the same cycle. This matters most when the read targets the status word, the capability pointer or the current tail entry, whose next pointer the load rewrites. The bench drives both in one cycle while the tail entry is read. It expects the old next pointer of 0, and then a follow-up read that shows the new link. The scoreboard builds each expectation from its own list model at issue time, before it applies the load, so it sees the state from before the load.

// File: rtl/cfgsp_pkg.sv
// Shared encodings for the configuration space block.
// Assumes byte offsets of 8 bits (256-byte space) and dword-granular storage.
package cfgsp_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Header dword indices that carry registers.
    localparam int unsigned DW_IDENT  = 0;
    localparam int unsigned DW_CMDSTS = 1;
    localparam int unsigned DW_CAPPTR = 13;
    localparam int unsigned DW_INTR   = 15;
    localparam int unsigned HDR_DWORDS = 16;
    localparam int unsigned STS_CAP_BIT = 20; // bit 4 of the status half

    // Mask covering the bytes of an access of the given size.
    function automatic logic [31:0] size_mask(input acc_size_e sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgsp_access_dec.sv
// Access decoder: checks natural alignment and derives the dword index
// and the byte enables inside that dword. Purely combinational.
// Assumes size codes from cfgsp_pkg; code 3 is always an error.
module cfgsp_access_dec
    import cfgsp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic              misaligned,
    output logic [ADDR_W-3:0] dw_idx,
    output logic [3:0]        byte_en
);
    // Alignment rule per size.
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = |addr[1:0];
            default: misaligned = 1'b1;
        endcase
    end

    // Byte lanes touched inside the addressed dword.
    always_comb begin
        case (size)
            SZ_BYTE: byte_en = 4'b0001 << addr[1:0];
            SZ_HALF: byte_en = 4'b0011 << addr[1:0];
            SZ_WORD: byte_en = 4'b1111;
            default: byte_en = 4'b0000;
        endcase
    end

    assign dw_idx = addr[ADDR_W-1:2];
endmodule

// File: rtl/cfgsp_hdr_regs.sv
// Standard header region (dwords 0..15): identity, status with the
// capability-present flag, capability pointer, interrupt line/pin.
// Only bytes selected by RW_MASK in the interrupt dword are writable.
// Assumes byte-lane-aligned write data and a qualified write strobe.
module cfgsp_hdr_regs
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID = 16'h7A21,
    parameter logic [7:0]  INT_PIN   = 8'h01,
    parameter logic [7:0]  CAP_BASE  = 8'h44,
    parameter int unsigned DW_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW_W-1:0] dw_idx,
    input  logic [3:0]      byte_en,
    input  logic [31:0]     wr_lane,
    input  logic            list_nonempty,
    output logic            hdr_hit,
    output logic [31:0]     hdr_dword
);
    localparam logic [31:0] RW_MASK = 32'h0000_00FF;

    logic [31:0] intr_q;
    logic [31:0] lane_mask;
    logic        intr_wr;

    // Expand byte enables to a bit mask restricted to writable bits.
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            lane_mask[b*8 +: 8] = {8{byte_en[b]}};
        end
        lane_mask = lane_mask & RW_MASK;
    end

    assign intr_wr = wr_en && (dw_idx == DW_W'(DW_INTR)) && (|lane_mask);
    assign hdr_hit = (dw_idx < DW_W'(HDR_DWORDS));

    // Interrupt dword: merge writable bytes, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= '0;
        end else if (intr_wr) begin
            intr_q <= (intr_q & ~lane_mask) | (wr_lane & lane_mask);
        end
    end

    // Read mux over the header dwords.
    always_comb begin
        hdr_dword = '0;
        if (hdr_hit) begin
            case (int'(dw_idx))
                DW_IDENT:  hdr_dword = {DEVICE_ID, VENDOR_ID};
                DW_CMDSTS: hdr_dword = 32'(list_nonempty) << STS_CAP_BIT;
                DW_CAPPTR: hdr_dword = {24'h0, list_nonempty ? CAP_BASE : 8'h00};
                DW_INTR:   hdr_dword = (intr_q & RW_MASK) | {16'h0, INT_PIN, 8'h00};
                default:   hdr_dword = '0;
            endcase
        end
    end

    // R4: interrupt line holds unless a write hits its byte.
    p_intline_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && dw_idx == DW_W'(DW_INTR) && byte_en[0]) |=> $stable(intr_q[7:0]));
endmodule

// File: rtl/cfgsp_cap_list.sv
// Capability list: CAP_MAX four-byte slots from CAP_BASE upward, filled in
// load order. Each slot's next pointer is derived from the fill count,
// so the chain always ends at the newest entry.
// Assumes CAP_BASE is dword aligned and CAP_BASE + 4*CAP_MAX <= 256.
module cfgsp_cap_list #(
    parameter int unsigned CAP_MAX  = 8,
    parameter logic [7:0]  CAP_BASE = 8'h44,
    parameter int unsigned DW_W     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_valid,
    input  logic [7:0]      load_id,
    input  logic [15:0]     load_data,
    input  logic [DW_W-1:0] dw_idx,
    output logic            cap_hit,
    output logic [31:0]     cap_dword,
    output logic            list_nonempty,
    output logic            load_done,
    output logic            load_err
);
    localparam int unsigned CNT_W   = $clog2(CAP_MAX + 1);
    localparam int unsigned BASE_DW = int'(CAP_BASE) / 4;

    logic [CNT_W-1:0] count_q;
    logic             full;
    logic             accept;
    logic [31:0]      slot_dw [CAP_MAX];
    logic [DW_W-1:0]  rel;

    assign full          = (count_q == CNT_W'(CAP_MAX));
    assign accept        = load_valid && !full;
    assign list_nonempty = (count_q != '0);

    // Fill count: grows by one per accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (accept) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Load handshake result, one cycle after the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_done <= 1'b0;
            load_err  <= 1'b0;
        end else begin
            load_done <= load_valid;
            load_err  <= load_valid && full;
        end
    end

    for (genvar k = 0; k < CAP_MAX; k++) begin : g_slot
        localparam logic [7:0] NEXT_OFS = 8'(int'(CAP_BASE) + 4 * (k + 1));
        logic [7:0]  id_q;
        logic [15:0] dat_q;
        logic        used;
        logic        linked;

        // Slot storage, written once when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_q  <= '0;
                dat_q <= '0;
            end else if (accept && count_q == CNT_W'(k)) begin
                id_q  <= load_id;
                dat_q <= load_data;
            end
        end

        assign used   = (count_q > CNT_W'(k));
        assign linked = (count_q > CNT_W'(k + 1));
        // Entry image with hardware-built next pointer.
        assign slot_dw[k] = used ? {dat_q, (linked ? NEXT_OFS : 8'h00), id_q} : 32'h0;
    end

    assign rel     = dw_idx - DW_W'(BASE_DW);
    assign cap_hit = (dw_idx >= DW_W'(BASE_DW)) && (rel < DW_W'(CAP_MAX));

    // Slot read mux.
    always_comb begin
        cap_dword = '0;
        for (int k = 0; k < CAP_MAX; k++) begin
            if (cap_hit && rel == DW_W'(k)) cap_dword = slot_dw[k];
        end
    end

    // R9: the count never passes the slot count.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(CAP_MAX));
    // R8: an accepted load extends the list by exactly one.
    p_append_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !full) |=> (count_q == $past(count_q) + 1'b1) && load_done && !load_err);
    // R9: a load into a full list is refused and changes nothing.
    p_full_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && full) |=> load_err && $stable(count_q));
endmodule

// File: rtl/cfgsp_func.sv
// Top: per-function configuration space. Decodes each request, routes it
// to the header or capability region, and registers a one-cycle response
// with right-justified read data. Capability loads arrive on their own port.
// Assumes one request per cycle; reads see state from before a same-cycle load.
module cfgsp_func
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID = 16'h7A21,
    parameter logic [7:0]  INT_PIN   = 8'h01,
    parameter int unsigned CAP_MAX   = 8,
    parameter logic [7:0]  CAP_BASE  = 8'h44
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    input  logic        cap_load_valid,
    input  logic [7:0]  cap_load_id,
    input  logic [15:0] cap_load_data,
    output logic        cap_done,
    output logic        cap_err
);
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DW_W   = ADDR_W - 2;

    acc_size_e       size;
    logic            misaligned;
    logic [DW_W-1:0] dw_idx;
    logic [3:0]      byte_en;
    logic [31:0]     wr_lane;
    logic            hdr_hit, cap_hit, nonempty;
    logic [31:0]     hdr_dword, cap_dword, sel_dword, rd_val;
    logic            wr_ok;

    assign size    = acc_size_e'(req_size);
    assign wr_lane = req_wdata << {req_addr[1:0], 3'b000};
    assign wr_ok   = req_valid && req_write && !misaligned;

    cfgsp_access_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (req_addr),
        .size       (size),
        .misaligned (misaligned),
        .dw_idx     (dw_idx),
        .byte_en    (byte_en)
    );

    cfgsp_hdr_regs #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .INT_PIN   (INT_PIN),
        .CAP_BASE  (CAP_BASE),
        .DW_W      (DW_W)
    ) u_hdr (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_ok),
        .dw_idx        (dw_idx),
        .byte_en       (byte_en),
        .wr_lane       (wr_lane),
        .list_nonempty (nonempty),
        .hdr_hit       (hdr_hit),
        .hdr_dword     (hdr_dword)
    );

    cfgsp_cap_list #(
        .CAP_MAX  (CAP_MAX),
        .CAP_BASE (CAP_BASE),
        .DW_W     (DW_W)
    ) u_caps (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_valid    (cap_load_valid),
        .load_id       (cap_load_id),
        .load_data     (cap_load_data),
        .dw_idx        (dw_idx),
        .cap_hit       (cap_hit),
        .cap_dword     (cap_dword),
        .list_nonempty (nonempty),
        .load_done     (cap_done),
        .load_err      (cap_err)
    );

    // Region select; unmapped offsets fall through to zero.
    always_comb begin
        if (hdr_hit)      sel_dword = hdr_dword;
        else if (cap_hit) sel_dword = cap_dword;
        else              sel_dword = '0;
    end

    // Right-justify the addressed bytes and trim to the access width.
    assign rd_val = (sel_dword >> {req_addr[1:0], 3'b000}) & size_mask(size);

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && misaligned;
            rsp_rdata <= (req_valid && !req_write && !misaligned) ? rd_val : 32'h0;
        end
    end

    // R2: every request is answered in the next cycle.
    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1: an unaligned word access is refused.
    p_misalign_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));
    // R1: an unaligned half access is refused.
    p_misalign_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1 && req_addr[0]) |=> rsp_err);
    // R5: status flag read follows the list having an entry.
    p_status_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd0 && req_addr == 8'h06 && !nonempty)
        |=> rsp_rdata == 32'h0);
endmodule

// File: tb/sim_cfgsp_func.sv
// Scoreboard bench: driver tasks push expected responses computed from a
// small model of the requirements; a monitor pops and compares them.
module sim_cfgsp_func;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VEN = 16'h1D0F;
    localparam logic [15:0] DEV = 16'h7A21;
    localparam logic [7:0]  PIN = 8'h01;
    localparam int CAPN = 8;
    localparam int BASE = 'h44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [7:0] req_addr = 0;
    logic [1:0] req_size = 0;
    logic [31:0] req_wdata = 0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic cap_load_valid = 0;
    logic [7:0] cap_load_id = 0;
    logic [15:0] cap_load_data = 0;
    logic cap_done, cap_err;

    int total = 0;
    int bad = 0;

    logic [32:0] q_exp [$];
    string       q_tag [$];

    // model state
    int          m_n = 0;
    logic [7:0]  m_id [CAPN];
    logic [15:0] m_dat [CAPN];
    logic [7:0]  m_line = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgsp_func u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cap_load_valid(cap_load_valid), .cap_load_id(cap_load_id),
        .cap_load_data(cap_load_data), .cap_done(cap_done), .cap_err(cap_err)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_dword(input int dw);
        m_dword = 0;
        if (dw == 0) m_dword = {DEV, VEN};
        else if (dw == 1) m_dword = (m_n > 0) ? 32'h0010_0000 : 0;
        else if (dw == 13) m_dword = (m_n > 0) ? 32'(BASE) : 0;
        else if (dw == 15) m_dword = {16'h0, PIN, m_line};
        else if (dw >= BASE/4 && dw < BASE/4 + CAPN) begin
            int i = dw - BASE/4;
            if (i < m_n)
                m_dword = {m_dat[i], (i + 1 < m_n) ? 8'(BASE + 4*(i+1)) : 8'h00, m_id[i]};
        end
    endfunction

    // Driver: present one request at the current (negedge) time, record expectation.
    task automatic acc(input string tag, input bit wr, input logic [7:0] a,
                       input logic [1:0] sz, input logic [31:0] wd);
        bit err;
        logic [31:0] mask, rd;
        err = (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0);
        mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        rd = (err || wr) ? 0 : ((m_dword(int'(a[7:2])) >> (8*a[1:0])) & mask);
        q_exp.push_back({err, rd});
        q_tag.push_back(tag);
        if (wr && !err && a[7:2] == 15 && a[1:0] == 0) m_line = wd[7:0];
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    endtask

    task automatic load(input logic [7:0] id, input logic [15:0] d);
        if (m_n < CAPN) begin m_id[m_n] = id; m_dat[m_n] = d; m_n++; end
        cap_load_valid = 1; cap_load_id = id; cap_load_data = d;
    endtask

    // Advance one cycle; check load result when a load was driven.
    task automatic step(input string tag, input bit exp_lerr);
        bit had_load;
        had_load = cap_load_valid;
        @(posedge clk); #1;
        if (had_load) check(tag, {32'h0, cap_done}, 33'h1);
        if (had_load) check(tag, {32'h0, cap_err}, {32'h0, exp_lerr});
        @(negedge clk);
        req_valid = 0; req_write = 0; cap_load_valid = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] sz);
        acc(tag, 0, a, sz, 0); step(tag, 0);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        acc(tag, 1, a, sz, d); step(tag, 0);
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (q_exp.size() == 0) begin
                total++; bad++;
                $display("FAIL R2: actual=unexpected response expected=none");
            end else begin
                logic [32:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, {rsp_err, rsp_rdata}, e);
            end
        end
    end

    initial begin
        fork
            begin
                #(CLK_PERIOD * 100000);
                bad++; total++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                // R12 reset state
                check("R12 rsp idle", {32'h0, rsp_valid}, 33'h0);
                rd("R12 intline after reset", 8'h3C, 2);
                rd("R5 status empty", 8'h06, 1);
                rd("R6 capptr empty", 8'h34, 0);
                // R3 identity
                rd("R3 ident dword", 8'h00, 2);
                for (int i = 0; i < 4; i++) rd("R3 ident byte", 8'(i), 0);
                rd("R2 half at 2", 8'h02, 1);
                // R1 alignment
                rd("R1 half at 1", 8'h01, 1);
                rd("R1 word at 2", 8'h02, 2);
                rd("R1 size code 3", 8'h00, 3);
                wr("R1 bad write", 8'h3D, 1, 32'hFFFF);
                rd("R1 no effect", 8'h3C, 2);
                // R4 interrupt line
                wr("R4 byte write", 8'h3C, 0, 32'hAA);
                rd("R4 byte read", 8'h3C, 0);
                wr("R4 wide write", 8'h3C, 2, 32'h5555_5555);
                rd("R4 wide result", 8'h3C, 2);
                rd("R4 pin byte", 8'h3D, 0);
                // R10 read-only and unmapped
                wr("R10 ident write", 8'h00, 2, 32'hFFFF_FFFF);
                rd("R10 ident kept", 8'h00, 2);
                rd("R10 unmapped", 8'h80, 2);
                rd("R10 unmapped hdr", 8'h10, 2);
                // R7 first entry
                load(8'h09, 16'h2211); step("R7 load", 0);
                rd("R5 status set", 8'h06, 1);
                rd("R6 capptr", 8'h34, 0);
                rd("R7 entry", 8'h44, 2);
                rd("R2 entry upper half", 8'h46, 1);
                // R11 concurrent read of tail and load
                acc("R11 read during load", 0, 8'h44, 2, 0);
                load(8'h01, 16'hBEEF);
                step("R11 load", 0);
                rd("R11 link after load", 8'h44, 2);
                // R8 fill and walk
                for (int i = 2; i < CAPN; i++) begin
                    load(8'(i + 16), 16'(i * 257)); step("R8 load", 0);
                end
                for (int i = 0; i < CAPN; i++) rd("R8 chain walk", 8'(BASE + 4*i), 2);
                // R9 full
                load(8'h77, 16'h7777); step("R9 full load", 1);
                rd("R9 last entry", 8'(BASE + 4*(CAPN-1)), 2);
                rd("R9 past slots", 8'(BASE + 4*CAPN), 2);
                // R10 entry and capptr writes ignored
                wr("R10 entry write", 8'h44, 2, 32'h0);
                wr("R10 capptr write", 8'h34, 0, 32'h0);
                rd("R10 entry kept", 8'h44, 2);
                rd("R10 capptr kept", 8'h34, 0);
                repeat (3) @(negedge clk);
                if (q_exp.size() != 0) begin
                    total++; bad++;
                    $display("FAIL R2: actual=%0d pending expected=0", q_exp.size());
                end
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule